// File: doc/BRIEF.md
# Receive Admission Filter with Single Association and Duplicate Rejection

This block sits in a power-line link layer's receive path. For every incoming packet header that has already passed framing and integrity checks, it decides whether the packet is delivered to the host, dropped as a repeat, refused with a busy reply, or lost as an overrun. The decision depends on four things: the packet kind, whether the destination belongs to this node, whether the host still owes a read of the last packet, and a single stored receive association. That association holds the last source, the last destination, the last sequence number, and a countdown timer.

The timer is counted in ticks of a parameterised prescaler, so a real hold time of about 937 ms can be shortened in simulation. The host clears its pending state with a one-cycle read pulse. The requests for an acknowledgment or a busy reply are handed to a separate frame builder.

Top module: `rx_admit`

## Requirements
- R1: A header is addressed to this node when its destination is one of: own system and own node; own system and node 0; own system and the configured group node; or system 0 and node 0. Any other header produces a result cycle with every outcome low, and it changes no flag, timer or association.
- R2: The packet kind `hdr_kind` uses two bits: bit 1 set means acknowledged, and bit 0 set means addressed. While a delivered packet is still unread (`rc_attn` high), an acknowledged kind is refused and raises `busy_req`. An unacknowledged kind is an overrun. Neither changes the timer or the association.
- R3: With the timer expired, a header is accepted. An addressed kind loads the timer so that it stays running for HOLD_TICKS*TICK_CYCLES clock edges. A header sampled at edge k after the loading edge finds it running if k <= HOLD_TICKS*TICK_CYCLES. A non-addressed kind leaves the timer at zero.
- R4: With the timer running, an addressed header whose source and destination both equal the stored ones is a duplicate if its sequence number equals the stored one, and the timer is unchanged. Otherwise it is accepted and the timer reloads.
- R5: With the timer running, a non-addressed header, or an addressed header with a differing source or destination, is refused (acknowledged kind) or an overrun (unacknowledged kind).
- R6: `ack_req` pulses for every acknowledged-kind header that is accepted or found to be a duplicate.
- R7: `rc_attn` rises on each accepted, non-duplicate packet and stays high until a `host_read` pulse. If an acceptance and a read fall in the same cycle, the acceptance wins.
- R8: `rc_except` is set by a refusal, by an overrun, or by an acceptance whose source or destination differs from the stored association. It is cleared by `host_read`, and setting it wins over clearing it.
- R9: `rc_refused` and `rc_overrun` are set by their outcomes and held until `host_read`.
- R10: Result outputs are registered. `res_valid` pulses exactly one clock after `hdr_valid`, with at most one outcome high, and every outcome is low otherwise.
- R11: After reset, all outputs are low, the timer is expired, and no association is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | One-cycle strobe: header fields are valid |
| hdr_kind | input | 2 | Bit 1 acknowledged, bit 0 addressed |
| hdr_src_sys | input | SYS_W | Source system address |
| hdr_src_node | input | NODE_W | Source node address |
| hdr_dst_sys | input | SYS_W | Destination system address |
| hdr_dst_node | input | NODE_W | Destination node address |
| hdr_seq | input | SEQ_W | Link sequence number |
| cfg_own_sys | input | SYS_W | This node's system address |
| cfg_own_node | input | NODE_W | This node's node address |
| cfg_group_node | input | NODE_W | Configured group node address |
| host_read | input | 1 | Host has taken the pending packet |
| res_valid | output | 1 | Result cycle for the previous header |
| res_accept | output | 1 | Packet delivered to host |
| res_dup | output | 1 | Packet discarded as duplicate |
| res_refuse | output | 1 | Packet refused |
| res_overrun | output | 1 | Packet lost as overrun |
| ack_req | output | 1 | Request an acknowledgment frame |
| busy_req | output | 1 | Request a busy-failure frame |
| rc_attn | output | 1 | Delivered packet awaiting host |
| rc_except | output | 1 | Sticky receive exception |
| rc_refused | output | 1 | Sticky refusal flag |
| rc_overrun | output | 1 | Sticky overrun flag |

## Verification
Every outcome, request and flag change appears at the first rising edge after the edge that samples `hdr_valid` or `host_read`. The bench therefore drives on falling edges and compares all eleven outputs against its model at the falling edge that follows. The timer boundary is exercised by spacing headers at gaps around HOLD_TICKS*TICK_CYCLES edges. The model decides "running" by its own cycle countdown, so an off-by-one edge in the prescaler shows up as a wrong outcome at exactly that gap.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;

  typedef enum logic [2:0] {
    V_NONE    = 3'd0,
    V_ACCEPT  = 3'd1,
    V_DUP     = 3'd2,
    V_REFUSE  = 3'd3,
    V_OVERRUN = 3'd4
  } verdict_t;

  function automatic logic kind_is_ack(input logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_is_addr(input logic [1:0] k);
    return k[0];
  endfunction

endpackage

// File: rtl/rx_dest_match.sv
module rx_dest_match #(
  parameter int SYS_W  = 16,
  parameter int NODE_W = 16
) (
  input  logic [SYS_W-1:0]  dst_sys,
  input  logic [NODE_W-1:0] dst_node,
  input  logic [SYS_W-1:0]  own_sys,
  input  logic [NODE_W-1:0] own_node,
  input  logic [NODE_W-1:0] group_node,
  output logic              hit
);
  logic sys_own, sys_zero, node_zero;

  always_comb begin
    sys_own   = (dst_sys == own_sys);
    sys_zero  = (dst_sys == '0);
    node_zero = (dst_node == '0);
    hit = (sys_own && (dst_node == own_node))
        || (sys_own && node_zero)
        || (sys_own && (dst_node == group_node))
        || (sys_zero && node_zero);
  end
endmodule

// File: rtl/rx_assoc_timer.sv
module rx_assoc_timer #(
  parameter int TICK_CYCLES = 50000,
  parameter int HOLD_TICKS  = 937,
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1,
  localparam int TW = $clog2(HOLD_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [TW-1:0] ticks,
  output logic          expired
);
  logic [PW-1:0] presc;
  logic          tick_end;

  assign tick_end = (presc == PW'(TICK_CYCLES - 1));
  assign expired  = (ticks == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ticks <= '0;
      presc <= '0;
    end else if (load) begin
      ticks <= TW'(HOLD_TICKS);
      presc <= '0;
    end else if (!expired) begin
      if (tick_end) begin
        presc <= '0;
        ticks <= ticks - 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end else begin
      presc <= '0;
    end
  end
endmodule

// File: rtl/rx_admit_decide.sv
module rx_admit_decide
  import rx_admit_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] kind,
  input  logic       hit,
  input  logic       pending,
  input  logic       expired,
  input  logic       same_pair,
  input  logic       seq_eq,
  output verdict_t   verdict
);
  always_comb begin
    verdict = V_NONE;
    if (valid && hit) begin
      if (pending)
        verdict = kind_is_ack(kind) ? V_REFUSE : V_OVERRUN;
      else if (expired)
        verdict = V_ACCEPT;
      else if (kind_is_addr(kind) && same_pair)
        verdict = seq_eq ? V_DUP : V_ACCEPT;
      else
        verdict = kind_is_ack(kind) ? V_REFUSE : V_OVERRUN;
    end
  end
endmodule

// File: rtl/rx_admit.sv
module rx_admit
  import rx_admit_pkg::*;
#(
  parameter int SYS_W       = 16,
  parameter int NODE_W      = 16,
  parameter int SEQ_W       = 2,
  parameter int TICK_CYCLES = 50000,
  parameter int HOLD_TICKS  = 937
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [1:0]        hdr_kind,
  input  logic [SYS_W-1:0]  hdr_src_sys,
  input  logic [NODE_W-1:0] hdr_src_node,
  input  logic [SYS_W-1:0]  hdr_dst_sys,
  input  logic [NODE_W-1:0] hdr_dst_node,
  input  logic [SEQ_W-1:0]  hdr_seq,
  input  logic [SYS_W-1:0]  cfg_own_sys,
  input  logic [NODE_W-1:0] cfg_own_node,
  input  logic [NODE_W-1:0] cfg_group_node,
  input  logic              host_read,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_dup,
  output logic              res_refuse,
  output logic              res_overrun,
  output logic              ack_req,
  output logic              busy_req,
  output logic              rc_attn,
  output logic              rc_except,
  output logic              rc_refused,
  output logic              rc_overrun
);
  localparam int TW = $clog2(HOLD_TICKS + 1);

  logic [SYS_W-1:0]  a_src_sys, a_dst_sys;
  logic [NODE_W-1:0] a_src_node, a_dst_node;
  logic [SEQ_W-1:0]  a_seq;
  logic              a_valid;

  logic              dst_hit, same_pair, seq_eq, addr_changed;
  logic              tmr_expired, tmr_load;
  logic [TW-1:0]     tmr_ticks;
  verdict_t          verdict;
  logic              evt_accept, evt_dup, evt_refuse, evt_overrun;

  rx_dest_match #(.SYS_W(SYS_W), .NODE_W(NODE_W)) u_match (
    .dst_sys(hdr_dst_sys), .dst_node(hdr_dst_node),
    .own_sys(cfg_own_sys), .own_node(cfg_own_node),
    .group_node(cfg_group_node), .hit(dst_hit)
  );

  assign same_pair = a_valid
                  && (hdr_src_sys == a_src_sys) && (hdr_src_node == a_src_node)
                  && (hdr_dst_sys == a_dst_sys) && (hdr_dst_node == a_dst_node);
  assign seq_eq       = (hdr_seq == a_seq);
  assign addr_changed = a_valid && !same_pair;

  rx_admit_decide u_decide (
    .valid(hdr_valid), .kind(hdr_kind), .hit(dst_hit), .pending(rc_attn),
    .expired(tmr_expired), .same_pair(same_pair), .seq_eq(seq_eq),
    .verdict(verdict)
  );

  assign evt_accept  = (verdict == V_ACCEPT);
  assign evt_dup     = (verdict == V_DUP);
  assign evt_refuse  = (verdict == V_REFUSE);
  assign evt_overrun = (verdict == V_OVERRUN);
  assign tmr_load    = evt_accept && kind_is_addr(hdr_kind);

  rx_assoc_timer #(.TICK_CYCLES(TICK_CYCLES), .HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .ticks(tmr_ticks), .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_accept  <= 1'b0;
      res_dup     <= 1'b0;
      res_refuse  <= 1'b0;
      res_overrun <= 1'b0;
      ack_req     <= 1'b0;
      busy_req    <= 1'b0;
    end else begin
      res_valid   <= hdr_valid;
      res_accept  <= evt_accept;
      res_dup     <= evt_dup;
      res_refuse  <= evt_refuse;
      res_overrun <= evt_overrun;
      ack_req     <= kind_is_ack(hdr_kind) && (evt_accept || evt_dup);
      busy_req    <= kind_is_ack(hdr_kind) && evt_refuse;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_attn    <= 1'b0;
      rc_except  <= 1'b0;
      rc_refused <= 1'b0;
      rc_overrun <= 1'b0;
    end else begin
      if (evt_accept)     rc_attn <= 1'b1;
      else if (host_read) rc_attn <= 1'b0;
      if (evt_refuse || evt_overrun || (evt_accept && addr_changed)) rc_except <= 1'b1;
      else if (host_read) rc_except <= 1'b0;
      if (evt_refuse)     rc_refused <= 1'b1;
      else if (host_read) rc_refused <= 1'b0;
      if (evt_overrun)    rc_overrun <= 1'b1;
      else if (host_read) rc_overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_valid    <= 1'b0;
      a_src_sys  <= '0;
      a_src_node <= '0;
      a_dst_sys  <= '0;
      a_dst_node <= '0;
      a_seq      <= '0;
    end else if (evt_accept) begin
      a_valid    <= 1'b1;
      a_src_sys  <= hdr_src_sys;
      a_src_node <= hdr_src_node;
      a_dst_sys  <= hdr_dst_sys;
      a_dst_node <= hdr_dst_node;
      a_seq      <= hdr_seq;
    end
  end
endmodule

// File: rtl/rx_admit_chk.sv
module rx_admit_chk #(
  parameter int HOLD_TICKS = 937,
  localparam int TW = $clog2(HOLD_TICKS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hdr_valid,
  input logic [1:0]    hdr_kind,
  input logic          res_valid,
  input logic          res_accept,
  input logic          res_dup,
  input logic          res_refuse,
  input logic          res_overrun,
  input logic          ack_req,
  input logic          busy_req,
  input logic          rc_attn,
  input logic          rc_refused,
  input logic [TW-1:0] tmr_ticks
);
  // R10: result strobe tracks the header strobe by one edge
  p_res_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> res_valid);
  p_res_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !res_valid);
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({res_accept, res_dup, res_refuse, res_overrun}) <= 1);
  // R2: busy reply only with a refusal
  p_busy_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_req |-> res_refuse);
  // R6: acknowledgment only for accepted or duplicate packets
  p_ack_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (res_accept || res_dup));
  // R7: attention rises only on a delivery
  p_attn_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_attn) |-> res_accept);
  // R9: refusal latches its flag
  p_refused_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_refuse |-> rc_refused);
  // R3: addressed acceptance loads the full hold count
  p_timer_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid ##1 (res_accept && $past(hdr_kind[0])) |-> tmr_ticks == TW'(HOLD_TICKS));
  // R4: duplicate does not reload the timer
  p_dup_keeps_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid ##1 res_dup |-> tmr_ticks <= $past(tmr_ticks));
endmodule

bind rx_admit rx_admit_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
  .res_valid(res_valid), .res_accept(res_accept), .res_dup(res_dup),
  .res_refuse(res_refuse), .res_overrun(res_overrun),
  .ack_req(ack_req), .busy_req(busy_req), .rc_attn(rc_attn),
  .rc_refused(rc_refused), .tmr_ticks(tmr_ticks)
);

// File: tb/test_rx_admit.sv
`timescale 1ns/1ps
module test_rx_admit;
  localparam int SYS_W = 16, NODE_W = 16, SEQ_W = 2;
  localparam int TCK = 4, HLD = 5;
  localparam int SPAN = TCK * HLD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 1'b0, host_read = 1'b0;
  logic [1:0] hdr_kind = '0;
  logic [SYS_W-1:0] hdr_src_sys = '0, hdr_dst_sys = '0;
  logic [NODE_W-1:0] hdr_src_node = '0, hdr_dst_node = '0;
  logic [SEQ_W-1:0] hdr_seq = '0;
  logic [SYS_W-1:0] own_sys = 16'h0A0B;
  logic [NODE_W-1:0] own_node = 16'h0012, grp_node = 16'h0077;
  logic res_valid, res_accept, res_dup, res_refuse, res_overrun;
  logic ack_req, busy_req, rc_attn, rc_except, rc_refused, rc_overrun;

  always #10 clk = ~clk;

  rx_admit #(.SYS_W(SYS_W), .NODE_W(NODE_W), .SEQ_W(SEQ_W),
             .TICK_CYCLES(TCK), .HOLD_TICKS(HLD)) i_rx_admit (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
    .hdr_src_sys(hdr_src_sys), .hdr_src_node(hdr_src_node),
    .hdr_dst_sys(hdr_dst_sys), .hdr_dst_node(hdr_dst_node), .hdr_seq(hdr_seq),
    .cfg_own_sys(own_sys), .cfg_own_node(own_node), .cfg_group_node(grp_node),
    .host_read(host_read),
    .res_valid(res_valid), .res_accept(res_accept), .res_dup(res_dup),
    .res_refuse(res_refuse), .res_overrun(res_overrun),
    .ack_req(ack_req), .busy_req(busy_req), .rc_attn(rc_attn),
    .rc_except(rc_except), .rc_refused(rc_refused), .rc_overrun(rc_overrun)
  );

  // behavioural reference
  int  m_rem;
  bit  m_pend, m_has, m_exc, m_ref, m_ovr;
  int  m_ss, m_sn, m_ds, m_dn, m_sq;
  bit  e_val, e_acc, e_dup, e_ref, e_ovr, e_ack, e_busy;
  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_pend = 0; m_has = 0; m_exc = 0; m_ref = 0; m_ovr = 0;
      m_ss = 0; m_sn = 0; m_ds = 0; m_dn = 0; m_sq = 0;
      e_val = 0; e_acc = 0; e_dup = 0; e_ref = 0; e_ovr = 0; e_ack = 0; e_busy = 0;
    end else begin
      bit ack, adr, mine, same, acc, dup, rf, ov;
      ack = hdr_kind[1]; adr = hdr_kind[0];
      mine = (hdr_dst_sys == own_sys && (hdr_dst_node == own_node ||
              hdr_dst_node == 0 || hdr_dst_node == grp_node)) ||
             (hdr_dst_sys == 0 && hdr_dst_node == 0);
      same = m_has && m_ss == hdr_src_sys && m_sn == hdr_src_node &&
             m_ds == hdr_dst_sys && m_dn == hdr_dst_node;
      acc = 0; dup = 0; rf = 0; ov = 0;
      if (hdr_valid && mine) begin
        if (m_pend) begin rf = ack; ov = !ack; end
        else if (m_rem == 0) acc = 1;
        else if (adr && same) begin
          if (m_sq == hdr_seq) dup = 1; else acc = 1;
        end else begin rf = ack; ov = !ack; end
      end
      e_val = hdr_valid; e_acc = acc; e_dup = dup; e_ref = rf; e_ovr = ov;
      e_ack = ack && (acc || dup); e_busy = ack && rf;
      if (rf || ov || (acc && m_has && !same)) m_exc = 1; else if (host_read) m_exc = 0;
      if (rf) m_ref = 1; else if (host_read) m_ref = 0;
      if (ov) m_ovr = 1; else if (host_read) m_ovr = 0;
      if (acc) m_pend = 1; else if (host_read) m_pend = 0;
      if (acc && adr) m_rem = SPAN; else if (m_rem > 0) m_rem = m_rem - 1;
      if (acc) begin
        m_has = 1; m_ss = hdr_src_sys; m_sn = hdr_src_node;
        m_ds = hdr_dst_sys; m_dn = hdr_dst_node; m_sq = hdr_seq;
      end
    end
  end

  task automatic chk(input string what, input logic got, input bit exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", what, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 res_valid", res_valid, e_val);
      chk("R1/R3/R4 res_accept", res_accept, e_acc);
      chk("R4 res_dup", res_dup, e_dup);
      chk("R5/R2 res_refuse", res_refuse, e_ref);
      chk("R5/R2 res_overrun", res_overrun, e_ovr);
      chk("R6 ack_req", ack_req, e_ack);
      chk("R2 busy_req", busy_req, e_busy);
      chk("R7 rc_attn", rc_attn, m_pend);
      chk("R8 rc_except", rc_except, m_exc);
      chk("R9 rc_refused", rc_refused, m_ref);
      chk("R9 rc_overrun", rc_overrun, m_ovr);
    end
  end

  task automatic send(input logic [1:0] k, input int ss, input int sn,
                      input int ds, input int dn, input int sq, input bit rd = 0);
    @(negedge clk);
    hdr_valid = 1; hdr_kind = k; hdr_src_sys = SYS_W'(ss); hdr_src_node = NODE_W'(sn);
    hdr_dst_sys = SYS_W'(ds); hdr_dst_node = NODE_W'(dn); hdr_seq = SEQ_W'(sq);
    host_read = rd;
    @(negedge clk);
    hdr_valid = 0; host_read = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hread();
    @(negedge clk); host_read = 1;
    @(negedge clk); host_read = 0;
  endtask

  localparam int OS = 16'h0A0B, ON = 16'h0012, GN = 16'h0077;

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state at the ports
    chk("R11 rc_attn", rc_attn, 0);
    chk("R11 rc_except", rc_except, 0);
    chk("R11 res_valid", res_valid, 0);
    idle(2);
    send(2'b11, 5, 1, OS, ON, 0);          // accept, load timer (R3)
    send(2'b11, 5, 1, OS, ON, 1);          // pending: refuse (R2)
    send(2'b01, 5, 1, OS, ON, 1);          // pending: overrun (R2)
    hread();
    send(2'b11, 5, 1, OS, ON, 0);          // duplicate (R4)
    send(2'b11, 5, 1, OS, ON, 1);          // new seq: accept, reload (R4)
    hread();
    send(2'b11, 6, 2, OS, ON, 2);          // other source: refuse (R5)
    send(2'b00, 5, 1, OS, ON, 2);          // non-addressed while running: overrun (R5)
    hread();
    idle(SPAN + 2);
    send(2'b00, 6, 2, 0, 0, 0);            // expired broadcast: accept, no load (R3)
    hread();
    send(2'b10, 7, 3, OS, 0, 0);           // timer stays zero: accept
    hread();
    send(2'b01, 5, 1, OS, GN, 2);          // group, load (R1)
    hread();
    send(2'b11, 5, 1, 16'h1111, ON, 3);    // foreign system: ignored (R1)
    send(2'b11, 5, 1, OS, 16'h0055, 3);    // foreign node: ignored (R1)
    send(2'b01, 5, 1, OS, 0, 3);           // different dst while running: overrun
    hread();
    for (int g = SPAN - 3; g <= SPAN + 1; g++) begin
      idle(SPAN + 2);
      send(2'b11, 9, 4, OS, ON, 0, 1);     // accept with coincident read (R7)
      hread();
      idle(g);
      send(2'b11, 8, 8, OS, ON, 1);        // boundary of timer window (R3)
      hread();
    end
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired, R10 run did not finish: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule